// File: doc/BRIEF.md
# Immediate Constant Expander with Condition Flags

This block carries out the load-immediate step of a 36-bit datapath. An immediate instruction holds only an 18-bit constant field. A two-bit mode selects how that field is widened to a full register value. The block also updates four condition flags: negative, zero, range trap and a sticky trap summary. Two more inputs drive the flags: whether the destination register is treated as signed, and the sign the programmer gave the constant.

Decode logic presents the mode, the field and the two sign bits, then raises `exec_en`. On the next rising clock edge the block registers the widened value together with a one-cycle `wr_valid` strobe for the register file, and it updates the flag register. When `exec_en` is low, the outputs hold their values. The sticky flag is cleared only by reset.

Top module: `imm_load_unit`

## Requirements
- R1: With mode 2'b00 (both halves), the committed value has the 18-bit field in bits 35..18 and also in bits 17..0.
- R2: With mode 2'b01 (high), the committed value has the field in bits 35..18 and zeros in bits 17..0.
- R3: With mode 2'b10 (negative), the committed value has ones in bits 35..18 and the field in bits 17..0.
- R4: With mode 2'b11 (positive), the committed value has zeros in bits 35..18 and the field in bits 17..0. `dst_signed` and `const_neg` have no effect on the value in this mode.
- R5: N takes the value of `const_neg`, except in positive mode, where N is always 0. The destination signedness and whether the value fits do not affect N.
- R6: Z is 1 exactly when the committed value is all zeros. In negative mode, Z is always 0.
- R7: T is 1 when bit 35 of the committed value is 1 and `dst_signed` differs from `const_neg`. Otherwise T is 0. In positive mode, T is always 0.
- R8: R becomes 1 whenever a commit sets T. Otherwise R keeps its previous value. Only reset clears R.
- R9: A commit happens on a rising edge only while `exec_en` is 1, and `wr_valid` is 1 for exactly the cycle after each commit. While `exec_en` is 0, `wr_data` and all four flags hold.
- R10: A synchronous active-high `rst` clears `wr_data`, `wr_valid` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Commit the operation on this edge |
| mode | input | 2 | 00 both, 01 high, 10 negative, 11 positive |
| imm | input | 18 | Immediate field |
| dst_signed | input | 1 | Destination register treated as signed |
| const_neg | input | 1 | Constant was written as negative |
| wr_data | output | 36 | Registered widened value |
| wr_valid | output | 1 | Register-file write strobe, one cycle per commit |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_t | output | 1 | Range trap flag |
| flag_r | output | 1 | Sticky trap summary flag |

## Verification
The bench builds the block with its default half width of 18, so the 36-bit register width and the position of bit 35 match the intended datapath. A random 18-bit field rarely comes out as zero, all ones or only the top bit set. Directed operations therefore cover those values, so that Z in both-halves mode, T in high and negative modes, and the positive-mode override of a negative sign are all reached. Idle cycles and a mid-run reset, issued after R has been set, show the hold and clear behaviour of the sticky flag.

// File: rtl/imm_load_pkg.sv
package imm_load_pkg;
  typedef enum logic [1:0] {
    MODE_BOTH = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_NEG  = 2'b10,
    MODE_POS  = 2'b11
  } imm_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic t;
    logic r;
  } cond_flags_t;
endpackage

// File: rtl/imm_widen.sv
module imm_widen
  import imm_load_pkg::*;
#(
  parameter int HALF_W = 18,
  localparam int FULL_W = 2 * HALF_W
) (
  input  imm_mode_e          mode,
  input  logic [HALF_W-1:0]  imm,
  output logic [FULL_W-1:0]  value
);
  logic [HALF_W-1:0] upper;
  logic [HALF_W-1:0] lower;

  always_comb begin
    unique case (mode)
      MODE_BOTH: begin upper = imm;              lower = imm;              end
      MODE_HIGH: begin upper = imm;              lower = '0;               end
      MODE_NEG:  begin upper = {HALF_W{1'b1}};   lower = imm;              end
      default:   begin upper = '0;               lower = imm;              end
    endcase
  end

  assign value = {upper, lower};
endmodule

// File: rtl/imm_flag_logic.sv
module imm_flag_logic
  import imm_load_pkg::*;
#(
  parameter int FULL_W = 36
) (
  input  imm_mode_e          mode,
  input  logic [FULL_W-1:0]  value,
  input  logic               dst_signed,
  input  logic               const_neg,
  input  logic               sticky_prev,
  output cond_flags_t        next
);
  logic is_pos;
  logic top_bit;
  logic sign_clash;

  assign is_pos     = (mode == MODE_POS);
  assign top_bit    = value[FULL_W-1];
  assign sign_clash = dst_signed ^ const_neg;

  always_comb begin
    next.n = const_neg & ~is_pos;
    next.z = (value == '0) & (mode != MODE_NEG);
    next.t = ~is_pos & top_bit & sign_clash;
    next.r = sticky_prev | next.t;
  end
endmodule

// File: rtl/imm_load_unit.sv
module imm_load_unit
  import imm_load_pkg::*;
#(
  parameter int HALF_W = 18,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [1:0]        mode,
  input  logic [HALF_W-1:0] imm,
  input  logic              dst_signed,
  input  logic              const_neg,
  output logic [FULL_W-1:0] wr_data,
  output logic              wr_valid,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_t,
  output logic              flag_r
);
  imm_mode_e         mode_e;
  logic [FULL_W-1:0] widened;
  cond_flags_t       flags_q;
  cond_flags_t       flags_d;
  logic [FULL_W-1:0] data_q;
  logic              valid_q;

  assign mode_e = imm_mode_e'(mode);

  imm_widen #(.HALF_W(HALF_W)) u_widen (
    .mode  (mode_e),
    .imm   (imm),
    .value (widened)
  );

  imm_flag_logic #(.FULL_W(FULL_W)) u_flags (
    .mode        (mode_e),
    .value       (widened),
    .dst_signed  (dst_signed),
    .const_neg   (const_neg),
    .sticky_prev (flags_q.r),
    .next        (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      flags_q <= '0;
    end else begin
      valid_q <= exec_en;
      if (exec_en) begin
        data_q  <= widened;
        flags_q <= flags_d;
      end
    end
  end

  assign wr_data  = data_q;
  assign wr_valid = valid_q;
  assign flag_n   = flags_q.n;
  assign flag_z   = flags_q.z;
  assign flag_t   = flags_q.t;
  assign flag_r   = flags_q.r;
endmodule

// File: rtl/imm_load_unit_checker.sv
module imm_load_unit_checker #(
  parameter int HALF_W = 18,
  localparam int FULL_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_en,
  input logic [1:0]        mode,
  input logic [FULL_W-1:0] wr_data,
  input logic              wr_valid,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_t,
  input logic              flag_r
);
  assert_high_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_en && mode == 2'b01) |=> (wr_data[HALF_W-1:0] == '0));

  assert_neg_upper_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_en && mode == 2'b10) |=> (&wr_data[FULL_W-1:HALF_W]) && !flag_z);

  assert_pos_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && mode == 2'b11) |=> (wr_data[FULL_W-1:HALF_W] == '0));

  assert_pos_clears_nt_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && mode == 2'b11) |=> (!flag_n && !flag_t));

  assert_trap_sets_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    flag_t |-> flag_r);

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !$fell(flag_r));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> (!wr_valid && $stable(wr_data) && $stable(flag_n) &&
                  $stable(flag_z) && $stable(flag_t) && $stable(flag_r)));

  assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> wr_valid);
endmodule

bind imm_load_unit imm_load_unit_checker #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .exec_en  (exec_en),
  .mode     (mode),
  .wr_data  (wr_data),
  .wr_valid (wr_valid),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_t   (flag_t),
  .flag_r   (flag_r)
);

// File: tb/imm_load_unit_bench.sv
module imm_load_unit_bench;
  localparam int HW = 18;
  localparam int FW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exec_en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [HW-1:0] imm = '0;
  logic          dst_signed = 1'b0;
  logic          const_neg = 1'b0;
  logic [FW-1:0] wr_data;
  logic          wr_valid, flag_n, flag_z, flag_t, flag_r;

  int total = 0;
  int bad = 0;

  logic [FW-1:0] m_data;
  logic m_n, m_z, m_t, m_r;

  always #2.5 clk = ~clk;

  imm_load_unit #(.HALF_W(HW)) u_imm_load_unit (
    .clk(clk), .rst(rst), .exec_en(exec_en), .mode(mode), .imm(imm),
    .dst_signed(dst_signed), .const_neg(const_neg), .wr_data(wr_data),
    .wr_valid(wr_valid), .flag_n(flag_n), .flag_z(flag_z),
    .flag_t(flag_t), .flag_r(flag_r)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] widen(input logic [1:0] md, input logic [HW-1:0] f);
    case (md)
      2'b00:   return {f, f};
      2'b01:   return {f, {HW{1'b0}}};
      2'b10:   return {{HW{1'b1}}, f};
      default: return {{HW{1'b0}}, f};
    endcase
  endfunction

  function automatic string value_req(input logic [1:0] md);
    case (md)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic en, input logic [1:0] md, input logic [HW-1:0] f,
                       input logic ds, input logic cn);
    @(negedge clk);
    exec_en = en; mode = md; imm = f; dst_signed = ds; const_neg = cn;
    if (en) begin
      m_data = widen(md, f);
      m_n = (md == 2'b11) ? 1'b0 : cn;
      m_z = (md != 2'b10) && (m_data == '0);
      m_t = (md != 2'b11) && m_data[FW-1] && (ds != cn);
      m_r = m_r | m_t;
    end
    @(negedge clk);
    exec_en = 1'b0;
    check(en ? value_req(md) : "R9", 64'(wr_data), 64'(m_data));
    check("R5", 64'(flag_n), 64'(m_n));
    check("R6", 64'(flag_z), 64'(m_z));
    check("R7", 64'(flag_t), 64'(m_t));
    check("R8", 64'(flag_r), 64'(m_r));
    check("R9", 64'(wr_valid), 64'(en));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_data = '0; m_n = 0; m_z = 0; m_t = 0; m_r = 0;
    check("R10", 64'(wr_data), 64'd0);
    check("R10", 64'(wr_valid), 64'd0);
    check("R10", 64'({flag_n, flag_z, flag_t, flag_r}), 64'd0);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // directed corners
    apply(1, 2'b11, 18'h00000, 1, 1);  // R4 zero, negative sign ignored
    apply(1, 2'b00, 18'h00000, 0, 0);  // R1 zero -> Z
    apply(1, 2'b00, 18'h2AAAA, 0, 0);  // R1 top bit, unsigned nonneg: no trap
    apply(1, 2'b01, 18'h20000, 1, 0);  // R2 signed dest, nonneg: trap
    apply(0, 2'b10, 18'h00001, 0, 1);  // R9 idle holds
    apply(1, 2'b10, 18'h3FFFE, 0, 0);  // R3 unsigned nonneg: no trap, Z clear
    apply(1, 2'b10, 18'h3FFFE, 1, 1);  // R3 signed negative: no trap, R stays
    apply(1, 2'b10, 18'h00000, 0, 1);  // R3 unsigned negative: trap
    apply(1, 2'b11, 18'h3FFFF, 1, 0);  // R4 max positive
    apply(1, 2'b01, 18'h1FFFF, 1, 0);  // R2 top bit clear: no trap
    do_reset();                        // R10 clears sticky R
    apply(1, 2'b11, 18'h12345, 0, 1);  // R5 invalid sign in positive mode
    for (int i = 0; i < 400; i++) begin
      apply(($urandom % 4) != 0, 2'($urandom), HW'($urandom), 1'($urandom), 1'($urandom));
      if (i == 200) do_reset();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule